// File: doc/BRIEF.md
# Dual-Mode Synchronous FIFO with Status Flags

This block is a single-clock FIFO for 9-bit words with a power-of-two depth. It has two read modes. In standard mode a read enable copies the oldest stored word to the output register. In fall-through mode the oldest word is moved to the output on its own, and a read enable consumes it. The mode is taken from a select input while master reset is held, and it stays fixed until the next master reset.

Two status outputs change meaning with the mode. In standard mode they report empty and full. In fall-through mode they report that output data is ready and that there is room for a write. Three more flags behave the same way in both modes: half-full, almost-empty and almost-full. The almost thresholds come from offset inputs that another block drives. Partial reset empties the FIFO but leaves the mode as it is.

Top module: `dualmode_fifo`

## Requirements
- R1: `fwft_sel` is sampled only on clock edges while `mrst` is high (1 = fall-through, 0 = standard). Changes on `fwft_sel` at any other time have no effect on the mode.
- R2: In standard mode, `empty_or_ready` is 1 exactly when the fill level is 0, and `full_or_room` is 1 exactly when the fill level equals DEPTH.
- R3: In fall-through mode, `empty_or_ready` is 1 exactly when a word waits on `rd_data`, and `full_or_room` is 1 exactly when the fill level is below DEPTH. The fill level counts the stored words plus the word waiting at the output.
- R4: In standard mode, a read enable on a non-empty FIFO loads the oldest word into `rd_data` at that clock edge, in write order. Otherwise `rd_data` holds its value.
- R5: In fall-through mode, a word is moved to `rd_data` without any read enable whenever the output is free or being consumed. A word written to an empty FIFO appears, with `empty_or_ready` high, on the second clock edge after the write edge.
- R6: A write while the fill level equals DEPTH, and a standard-mode read while empty, are ignored. Stored contents and the level stay unchanged.
- R7: `half_full` is 1 exactly when the fill level is at least DEPTH/2.
- R8: `almost_empty` is 1 when the fill level is at most `ae_offset`. `almost_full` is 1 when DEPTH minus the fill level is at most `af_offset`.
- R9: Master reset (synchronous, active high) empties the FIFO, clears `rd_data` to 0 and sets every flag to match an empty FIFO.
- R10: Partial reset (synchronous, active high) empties the FIFO and clears `rd_data`, but keeps the latched mode.
- R11: All flags are registers. They show the level that results from a clock edge's write or read at that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| mrst | input | 1 | Master reset, synchronous, active high |
| prst | input | 1 | Partial reset, synchronous, active high |
| fwft_sel | input | 1 | Mode select, sampled during master reset |
| wr_en | input | 1 | Write request |
| wr_data | input | DATA_W | Write word |
| rd_en | input | 1 | Read request |
| rd_data | output | DATA_W | Read word |
| ae_offset | input | ADDR_W+1 | Almost-empty threshold |
| af_offset | input | ADDR_W+1 | Almost-full threshold |
| empty_or_ready | output | 1 | Empty (standard) or output ready (fall-through) |
| full_or_room | output | 1 | Full (standard) or input ready (fall-through) |
| half_full | output | 1 | Fill level at least half of depth |
| almost_empty | output | 1 | Fill level at or below the empty offset |
| almost_full | output | 1 | Free space at or below the full offset |

## Verification
On every cycle, the assertions check that the level never goes past the depth and that a write at full is refused. They also check that the mode holds between master resets, that partial reset empties the FIFO, and that the two status outputs and half-full match the internal level for the latched mode. They further check that a fall-through output never stays idle while a word is stored. Other behaviour can only be shown by the bench scenarios running against a queue model: word order, the two-edge fall-through latency, the almost thresholds as the offsets change, and the fact that the mode survives a partial reset and mode-select changes outside reset.

// File: rtl/dmf_pkg.sv
package dmf_pkg;

  typedef struct packed {
    logic stat_a;
    logic stat_b;
    logic half;
    logic near_empty;
    logic near_full;
  } flags_t;

  // Words the FIFO holds, counting the fall-through output stage.
  function automatic int unsigned fill_level(int unsigned stored, logic out_valid, logic fwft);
    return stored + ((fwft && out_valid) ? 1 : 0);
  endfunction

  function automatic flags_t derive_flags(int unsigned lvl, int unsigned depth,
                                          int unsigned ae_off, int unsigned af_off,
                                          logic out_valid, logic fwft);
    flags_t f;
    f.stat_a     = fwft ? out_valid : (lvl == 0);
    f.stat_b     = fwft ? (lvl < depth) : (lvl == depth);
    f.half       = (lvl >= depth / 2);
    f.near_empty = (lvl <= ae_off);
    f.near_full  = ((depth - lvl) <= af_off);
    return f;
  endfunction

endpackage

// File: rtl/dmf_mem.sv
module dmf_mem #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/dmf_flags.sv
module dmf_flags #(
  parameter int ADDR_W = 5
) (
  input  logic            clk,
  input  logic [ADDR_W:0] level_n,
  input  logic            ovalid_n,
  input  logic            fwft_n,
  input  logic [ADDR_W:0] ae_offset,
  input  logic [ADDR_W:0] af_offset,
  output logic            stat_a,
  output logic            stat_b,
  output logic            half_full,
  output logic            almost_empty,
  output logic            almost_full
);
  localparam int DEPTH = 1 << ADDR_W;

  dmf_pkg::flags_t f_n, f_q;

  always_comb begin
    f_n = dmf_pkg::derive_flags(int'(level_n), DEPTH, int'(ae_offset), int'(af_offset),
                                ovalid_n, fwft_n);
  end

  // Loaded on every edge from the post-edge level, so flags follow the operation at once.
  always_ff @(posedge clk) f_q <= f_n;

  assign stat_a       = f_q.stat_a;
  assign stat_b       = f_q.stat_b;
  assign half_full    = f_q.half;
  assign almost_empty = f_q.near_empty;
  assign almost_full  = f_q.near_full;
endmodule

// File: rtl/dualmode_fifo.sv
module dualmode_fifo #(
  parameter int DATA_W = 9,
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              mrst,
  input  logic              prst,
  input  logic              fwft_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  input  logic [ADDR_W:0]   ae_offset,
  input  logic [ADDR_W:0]   af_offset,
  output logic              empty_or_ready,
  output logic              full_or_room,
  output logic              half_full,
  output logic              almost_empty,
  output logic              almost_full
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int CW    = ADDR_W + 1;

  logic              fwft_q, fwft_n;
  logic [ADDR_W-1:0] wptr, rptr;
  logic [CW-1:0]     mcnt, mcnt_n;
  logic              ovalid, ovalid_n;
  logic [CW-1:0]     level, level_n;
  logic [DATA_W-1:0] mem_q;

  // Named internal events, also observed by the checker.
  logic wr_accept, rd_accept, consume, load, mem_pop;

  assign level     = CW'(dmf_pkg::fill_level(int'(mcnt), ovalid, fwft_q));
  assign wr_accept = wr_en && (level < CW'(DEPTH));
  assign rd_accept = !fwft_q && rd_en && (mcnt != '0);
  assign consume   = fwft_q && rd_en && ovalid;
  assign load      = fwft_q && (!ovalid || consume) && (mcnt != '0);
  assign mem_pop   = rd_accept || load;

  always_comb begin
    if (mrst) begin
      fwft_n   = fwft_sel;
      mcnt_n   = '0;
      ovalid_n = 1'b0;
    end else if (prst) begin
      fwft_n   = fwft_q;
      mcnt_n   = '0;
      ovalid_n = 1'b0;
    end else begin
      fwft_n   = fwft_q;
      mcnt_n   = mcnt + CW'(wr_accept) - CW'(mem_pop);
      ovalid_n = load ? 1'b1 : (consume ? 1'b0 : ovalid);
    end
    level_n = CW'(dmf_pkg::fill_level(int'(mcnt_n), ovalid_n, fwft_n));
  end

  always_ff @(posedge clk) begin
    fwft_q <= fwft_n;
    mcnt   <= mcnt_n;
    ovalid <= ovalid_n;
    if (mrst || prst) begin
      wptr    <= '0;
      rptr    <= '0;
      rd_data <= '0;
    end else begin
      if (wr_accept) wptr <= wptr + 1'b1;
      if (mem_pop) begin
        rptr    <= rptr + 1'b1;
        rd_data <= mem_q;
      end
    end
  end

  dmf_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk   (clk),
    .we    (wr_accept && !mrst && !prst),
    .waddr (wptr),
    .wdata (wr_data),
    .raddr (rptr),
    .rdata (mem_q)
  );

  dmf_flags #(.ADDR_W(ADDR_W)) u_flags (
    .clk          (clk),
    .level_n      (level_n),
    .ovalid_n     (ovalid_n),
    .fwft_n       (fwft_n),
    .ae_offset    (ae_offset),
    .af_offset    (af_offset),
    .stat_a       (empty_or_ready),
    .stat_b       (full_or_room),
    .half_full    (half_full),
    .almost_empty (almost_empty),
    .almost_full  (almost_full)
  );
endmodule

// File: rtl/dmf_checker.sv
module dmf_checker #(
  parameter int ADDR_W = 5
) (
  input logic            clk,
  input logic            mrst,
  input logic            prst,
  input logic            fwft_q,
  input logic [ADDR_W:0] level,
  input logic            ovalid,
  input logic            wr_accept,
  input logic            stat_a,
  input logic            stat_b,
  input logic            half_full
);
  localparam int DEPTH = 1 << ADDR_W;

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (mrst)
    int'(level) <= DEPTH);

  assert_full_rejects_R6: assert property (@(posedge clk) disable iff (mrst)
    (int'(level) == DEPTH) |-> !wr_accept);

  assert_mode_hold_R1: assert property (@(posedge clk) disable iff (mrst)
    !mrst |=> $stable(fwft_q));

  assert_prst_empties_R10: assert property (@(posedge clk) disable iff (mrst)
    prst |=> (level == '0 && !ovalid));

  assert_std_flags_R2: assert property (@(posedge clk) disable iff (mrst)
    !fwft_q |-> (stat_a == (level == '0) && stat_b == (int'(level) == DEPTH)));

  assert_fwft_flags_R3: assert property (@(posedge clk) disable iff (mrst)
    fwft_q |-> (stat_a == ovalid && stat_b == (int'(level) < DEPTH)));

  assert_half_R7: assert property (@(posedge clk) disable iff (mrst)
    half_full == (int'(level) >= DEPTH / 2));

  assert_fall_through_R5: assert property (@(posedge clk) disable iff (mrst)
    (fwft_q && !ovalid && level != '0 && !prst) |=> ovalid);
endmodule

bind dualmode_fifo dmf_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .mrst      (mrst),
  .prst      (prst),
  .fwft_q    (fwft_q),
  .level     (level),
  .ovalid    (ovalid),
  .wr_accept (wr_accept),
  .stat_a    (empty_or_ready),
  .stat_b    (full_or_room),
  .half_full (half_full)
);

// File: tb/dualmode_fifo_tb.sv
module dualmode_fifo_tb;
  localparam int DATA_W = 9;
  localparam int ADDR_W = 5;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic mrst = 1'b1, prst = 1'b0, fwft_sel = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [DATA_W-1:0] wr_data = '0;
  logic [DATA_W-1:0] rd_data;
  logic [ADDR_W:0] ae_offset = 6'd3, af_offset = 6'd4;
  logic empty_or_ready, full_or_room, half_full, almost_empty, almost_full;

  always #5 clk = ~clk;

  dualmode_fifo #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .mrst(mrst), .prst(prst), .fwft_sel(fwft_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .ae_offset(ae_offset), .af_offset(af_offset),
    .empty_or_ready(empty_or_ready), .full_or_room(full_or_room),
    .half_full(half_full), .almost_empty(almost_empty), .almost_full(almost_full)
  );

  // Behavioural reference: a queue of stored words plus a fall-through output slot.
  bit               m_fwft;
  logic [DATA_W-1:0] m_q[$];
  bit               m_ov;
  int               m_out;
  int compared = 0, mismatched = 0;

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int model_level();
    return m_q.size() + ((m_fwft && m_ov) ? 1 : 0);
  endfunction

  task automatic model_edge();
    int lvl;
    bit wacc, cons;
    if (mrst) begin
      m_fwft = fwft_sel; m_q.delete(); m_ov = 0; m_out = 0;
    end else if (prst) begin
      m_q.delete(); m_ov = 0; m_out = 0;
    end else begin
      lvl  = model_level();
      wacc = wr_en && (lvl < DEPTH);
      if (!m_fwft) begin
        if (rd_en && m_q.size() > 0) m_out = int'(m_q.pop_front());
      end else begin
        cons = rd_en && m_ov;
        if ((!m_ov || cons) && m_q.size() > 0) begin
          m_out = int'(m_q.pop_front()); m_ov = 1;
        end else if (cons) m_ov = 0;
      end
      if (wacc) m_q.push_back(wr_data);
    end
  endtask

  task automatic compare_all();
    int lvl = model_level();
    if (!m_fwft) begin
      check("R2 empty flag", int'(empty_or_ready), int'(lvl == 0));
      check("R2 full flag", int'(full_or_room), int'(lvl == DEPTH));
      check("R4 standard read data", int'(rd_data), m_out);
    end else begin
      check("R3 output ready", int'(empty_or_ready), int'(m_ov));
      check("R3 input ready", int'(full_or_room), int'(lvl < DEPTH));
      if (m_ov) check("R5 fall-through data", int'(rd_data), m_out);
    end
    check("R7 half full", int'(half_full), int'(lvl >= DEPTH / 2));
    check("R8 almost empty", int'(almost_empty), int'(lvl <= int'(ae_offset)));
    check("R8 almost full", int'(almost_full), int'((DEPTH - lvl) <= int'(af_offset)));
  endtask

  // Called at a falling edge: drive, let the rising edge pass, compare at the next falling edge.
  task automatic cyc(bit w, int d, bit r);
    wr_en = w; wr_data = DATA_W'(d); rd_en = r;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_mrst(bit mode);
    mrst = 1'b1; fwft_sel = mode;
    cyc(0, 0, 0); cyc(0, 0, 0);
    mrst = 1'b0;
  endtask

  task automatic random_run(int n, int wr_pct, int rd_pct);
    for (int i = 0; i < n; i++)
      cyc($urandom_range(99) < wr_pct, $urandom_range(511), $urandom_range(99) < rd_pct);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL R11 watchdog expired actual=running expected=finished");
    finish_run();
  end

  initial begin
    @(negedge clk);
    // R9: master reset into standard mode.
    do_mrst(1'b0);
    check("R9 reset empty flag", int'(empty_or_ready), 1);
    check("R9 reset rd_data", int'(rd_data), 0);
    check("R9 reset almost_empty", int'(almost_empty), 1);

    // R11: a single write clears the empty flag at its own edge.
    cyc(1, 9'h011, 0);
    check("R11 flag after one write", int'(empty_or_ready), 0);
    for (int i = 0; i < 4; i++) cyc(1, 9'h020 + i, 0);
    for (int i = 0; i < 6; i++) cyc(0, 0, 1);   // last read is on an empty FIFO (R6)
    check("R6 read while empty keeps data", int'(rd_data), 9'h023);

    // R1: mode select moves outside reset; standard behaviour must stay.
    fwft_sel = 1'b1;
    cyc(1, 9'h0B1, 0); cyc(0, 0, 0); cyc(0, 0, 0);
    check("R1 mode unchanged, still empty flag", int'(empty_or_ready), 0);
    check("R1 no fall-through in standard mode", int'(rd_data), 9'h023);

    // R6: fill past full, then simultaneous read/write at full, then drain.
    for (int i = 0; i < DEPTH + 2; i++) cyc(1, 9'h100 + i, 0);
    check("R6 full flag held", int'(full_or_room), 1);
    cyc(1, 9'h1AA, 1);
    ae_offset = 6'd10; af_offset = 6'd0;
    for (int i = 0; i < DEPTH + 3; i++) cyc(0, 0, 1);

    // R10: partial reset with data stored, mode stays standard.
    for (int i = 0; i < 7; i++) cyc(1, 9'h040 + i, 0);
    prst = 1'b1; cyc(0, 0, 0); prst = 1'b0;
    check("R10 partial reset empties", int'(empty_or_ready), 1);
    cyc(1, 9'h055, 0); cyc(0, 0, 0); cyc(0, 0, 0);
    check("R10 mode kept standard", int'(rd_data), 0);
    random_run(300, 70, 30);
    random_run(300, 30, 70);

    // R5: fall-through mode.
    ae_offset = 6'd3; af_offset = 6'd4;
    do_mrst(1'b1);
    check("R9 fall-through reset input ready", int'(full_or_room), 1);
    cyc(1, 9'h0A5, 0);
    check("R5 not ready one edge after write", int'(empty_or_ready), 0);
    cyc(0, 0, 0);
    check("R5 ready two edges after write", int'(empty_or_ready), 1);
    check("R5 word falls through", int'(rd_data), 9'h0A5);
    for (int i = 0; i < DEPTH + 2; i++) cyc(1, 9'h0C0 + i, 0);
    check("R6 fall-through input not ready at full", int'(full_or_room), 0);
    cyc(1, 9'h1EE, 1);
    for (int i = 0; i < 10; i++) cyc(0, 0, 1);

    // R10 in fall-through mode: mode is kept.
    prst = 1'b1; cyc(0, 0, 0); prst = 1'b0;
    check("R10 partial reset clears ready", int'(empty_or_ready), 0);
    cyc(1, 9'h077, 0); cyc(0, 0, 0);
    check("R10 fall-through mode kept", int'(rd_data), 9'h077);
    random_run(300, 70, 30);
    random_run(300, 30, 70);
    random_run(200, 50, 50);
    finish_run();
  end
endmodule